// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block is the send half of one serial channel. Bytes arrive on a valid/ready stream and wait in a small first-in first-out queue. A frame shifter takes them from the queue and puts each one on a single output line as an asynchronous character. Every bit on the line lasts a fixed number of pulses of an oversampling enable. Nothing inside the block makes that enable; it comes from an external rate divider.

Software picks the settings on plain control pins: a character length of five to eight data bits, no parity or a parity bit of either sense, and a break control that holds the line low. A status output goes high once every accepted byte has been fully sent.

The byte stream obeys valid/ready rules. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` falls while the queue is full. A source that sees `in_ready` low must hold its byte and try again. Any byte it offers while `in_ready` is low is dropped. The block never stalls a byte it has already taken.

Top module: `ser_async_tx`

## Requirements
- R1: After reset, `txd` is high, `tx_empty` is high and `in_ready` is high. Whenever the block has nothing to send and break is off, `txd` is high.
- R2: A frame has four parts in this order: one low start bit, the data bits with bit 0 first, an optional parity bit, and one high stop bit. Each bit lasts 16 `baud_tick` pulses.
- R3: `cfg_len` sets the number of data bits: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Byte bits above the chosen length are never sent and have no effect on the parity bit.
- R4: With `cfg_par_en` high, a parity bit follows the data. `cfg_par_odd` = 0 makes the count of ones across the data and parity bits even. `cfg_par_odd` = 1 makes that count odd. With `cfg_par_en` low, the stop bit follows the last data bit directly.
- R5: Length and parity settings are captured when a character is loaded. Changing them during a frame does not alter that frame.
- R6: While `cfg_brk` is high, `txd` is low from the same cycle on. The frame continues to advance underneath, so bit positions and the end-of-frame time are unchanged when break is released.
- R7: A character starts on the first `baud_tick` on which the shifter is idle and the queue holds a byte. When a byte is waiting as a stop bit ends, its start bit begins on that same tick, with no idle gap.
- R8: The queue holds 16 bytes and sends them in the order they were accepted. `in_ready` is low while all 16 are held. A byte offered while `in_ready` is low is dropped and never sent.
- R9: `tx_empty` is high only when the queue is empty and no frame is in progress. It rises on the tick that ends the last stop bit.
- R10: The line and the frame state change only in the cycle after a `baud_tick`. Without ticks, `txd` holds its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Oversampling enable, one pulse per 1/16 bit |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready (queue not full) |
| in_data | input | 8 | Byte to send, bit 0 goes first |
| cfg_len | input | 2 | Character length code, 0..3 for 5..8 bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| cfg_brk | input | 1 | Forces the line low while high |
| txd | output | 1 | Serial output line, idles high |
| tx_empty | output | 1 | Queue empty and shifter idle |

## Verification
The hardest state to reach is a full queue combined with a rejected extra byte, followed by a run of back-to-back frames. In normal running the shifter drains the queue about as fast as a source fills it. The bench therefore stops the tick enable, loads 16 bytes, offers one more while `in_ready` is low, and then restarts the ticks. It then decodes all 16 frames and checks their order, checks that each start bit falls exactly one frame time after the previous one, and checks that the line stays idle afterwards. Frame-boundary timing under break, with ticks paused mid-bit, and with settings changed mid-frame is checked by counting ticks from the observed start edge.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  localparam int unsigned MIN_CHAR_BITS = 5;
  localparam int unsigned LEN_CODE_W    = 2;

  typedef logic [LEN_CODE_W-1:0] len_code_t;
endpackage

// File: rtl/ser_tx_fifo.sv
module ser_tx_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_valid,
  output logic                            wr_ready,
  input  logic [W-1:0]                    wr_data,
  output logic                            rd_valid,
  output logic [W-1:0]                    rd_data,
  input  logic                            rd_pop,
  output logic [$clog2(DEPTH+1)-1:0]      level
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          push, pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_ready = (cnt != CW'(DEPTH));
  assign rd_valid = (cnt != '0);
  assign rd_data  = mem[rd_ptr];
  assign level    = cnt;
  assign push     = wr_valid & wr_ready;
  assign pop      = rd_pop & rd_valid;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ser_parity.sv
module ser_parity
  import ser_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] data,
  input  len_code_t    len,
  input  logic         odd,
  output logic         par
);
  logic [W-1:0] mask;

  for (genvar i = 0; i < W; i++) begin : g_mask
    if (i < MIN_CHAR_BITS) begin : g_always
      assign mask[i] = 1'b1;
    end else begin : g_by_len
      assign mask[i] = (int'(len) + int'(MIN_CHAR_BITS)) > i;
    end
  end

  assign par = (^(data & mask)) ^ odd;
endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter
  import ser_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned OVS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         baud_tick,
  input  logic         src_valid,
  input  logic [W-1:0] src_data,
  output logic         src_pop,
  input  len_code_t    cfg_len,
  input  logic         cfg_par_en,
  input  logic         cfg_par_odd,
  output logic         line,
  output logic         busy
);
  localparam int unsigned TW = $clog2(OVS);
  localparam int unsigned BW = $clog2(W);

  tx_state_e     state_q;
  logic [TW-1:0] tcnt_q;
  logic [BW-1:0] bidx_q, last_q;
  logic [W-1:0]  sh_q;
  logic          pen_q, par_q;
  logic          par_next, bit_done, take;

  ser_parity #(.W(W)) i_par (
    .data (src_data),
    .len  (cfg_len),
    .odd  (cfg_par_odd),
    .par  (par_next)
  );

  assign bit_done = (tcnt_q == TW'(OVS - 1));
  assign take     = baud_tick && src_valid &&
                    ((state_q == ST_IDLE) || ((state_q == ST_STOP) && bit_done));
  assign src_pop  = take;
  assign busy     = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      last_q  <= '0;
      sh_q    <= '0;
      pen_q   <= 1'b0;
      par_q   <= 1'b0;
    end else if (take) begin
      state_q <= ST_START;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      last_q  <= BW'(int'(cfg_len) + int'(MIN_CHAR_BITS) - 1);
      sh_q    <= src_data;
      pen_q   <= cfg_par_en;
      par_q   <= par_next;
    end else if (baud_tick && (state_q != ST_IDLE)) begin
      if (!bit_done) begin
        tcnt_q <= tcnt_q + 1'b1;
      end else begin
        tcnt_q <= '0;
        case (state_q)
          ST_START: begin
            state_q <= ST_DATA;
            bidx_q  <= '0;
          end
          ST_DATA: begin
            sh_q <= sh_q >> 1;
            if (bidx_q == last_q) state_q <= pen_q ? ST_PAR : ST_STOP;
            else                  bidx_q  <= bidx_q + 1'b1;
          end
          ST_PAR:  state_q <= ST_STOP;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh_q[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end
endmodule

// File: rtl/ser_async_tx.sv
module ser_async_tx
  import ser_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned OVS        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_brk,
  output logic              txd,
  output logic              tx_empty
);
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

  logic              fifo_valid, fifo_pop;
  logic [DATA_W-1:0] fifo_data;
  logic [CW-1:0]     fifo_level;
  logic              ser_line, ser_busy;

  ser_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (in_valid),
    .wr_ready (in_ready),
    .wr_data  (in_data),
    .rd_valid (fifo_valid),
    .rd_data  (fifo_data),
    .rd_pop   (fifo_pop),
    .level    (fifo_level)
  );

  ser_tx_shifter #(.W(DATA_W), .OVS(OVS)) i_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .baud_tick   (baud_tick),
    .src_valid   (fifo_valid),
    .src_data    (fifo_data),
    .src_pop     (fifo_pop),
    .cfg_len     (len_code_t'(cfg_len)),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .line        (ser_line),
    .busy        (ser_busy)
  );

  assign txd      = ser_line & ~cfg_brk;
  assign tx_empty = ~fifo_valid & ~ser_busy;
endmodule

// File: rtl/ser_async_tx_chk.sv
module ser_async_tx_chk #(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           baud_tick,
  input logic                           in_valid,
  input logic                           in_ready,
  input logic                           cfg_brk,
  input logic                           txd,
  input logic                           tx_empty,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
  input logic                           fifo_pop,
  input logic                           ser_line
);
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !cfg_brk) |-> txd); // R1

  AST_POP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> baud_tick); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= CW'(FIFO_DEPTH)); // R8

  AST_REJECT_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (fifo_level <= $past(fifo_level))); // R8

  AST_EMPTY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $past(baud_tick)); // R9

  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(ser_line)); // R10
endmodule

bind ser_async_tx ser_async_tx_chk #(.FIFO_DEPTH(FIFO_DEPTH)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .baud_tick  (baud_tick),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .cfg_brk    (cfg_brk),
  .txd        (txd),
  .tx_empty   (tx_empty),
  .fifo_level (fifo_level),
  .fifo_pop   (fifo_pop),
  .ser_line   (ser_line)
);

// File: tb/test_ser_async_tx.sv
`timescale 1ns/1ps
module test_ser_async_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       tick_en = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_brk = 1'b0;
  logic       in_ready, txd, tx_empty;

  int checks = 0;
  int errors = 0;
  int tick_count = 0;

  // {len code[11:10], parity enable[9], odd[8], data[7:0]}
  localparam logic [11:0] VEC [8] = '{
    {2'd3, 1'b0, 1'b0, 8'hA5},
    {2'd3, 1'b1, 1'b0, 8'h01},
    {2'd3, 1'b1, 1'b1, 8'h03},
    {2'd0, 1'b0, 1'b0, 8'hFF},
    {2'd0, 1'b1, 1'b0, 8'hE3},
    {2'd1, 1'b1, 1'b1, 8'h2A},
    {2'd2, 1'b0, 1'b0, 8'h80},
    {2'd2, 1'b1, 1'b1, 8'h7F}
  };

  ser_async_tx i_ser_async_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_brk(cfg_brk), .txd(txd), .tx_empty(tx_empty)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) baud_tick <= tick_en ? ~baud_tick : 1'b0;
  always @(posedge clk) if (baud_tick) tick_count <= tick_count + 1;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1ms;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_tick(input int target);
    while (tick_count < target) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic find_start(output int t0);
    while (txd !== 1'b0) @(negedge clk);
    t0 = tick_count;
  endtask

  // Receives one frame using tick counts from the start edge; checks R2/R3/R4.
  task automatic rx_frame(input logic [1:0] len, input bit pen, input bit podd,
                          input logic [7:0] exp_d, output int t0);
    int n, ones;
    logic [7:0] got, expm;
    find_start(t0);
    n = 5 + int'(len);
    got = '0;
    ones = 0;
    expm = '0;
    for (int k = 0; k < n; k++) begin
      wait_tick(t0 + 16 * (k + 1) + 8);
      got[k] = txd;
      expm[k] = exp_d[k];
      if (exp_d[k]) ones++;
    end
    chk(got == expm, "R2/R3 data bits", got, expm);
    if (pen) begin
      wait_tick(t0 + 16 * (n + 1) + 8);
      chk(txd == ((ones % 2 == 1) ^ podd), "R4 parity bit", txd, (ones % 2 == 1) ^ podd);
    end
    wait_tick(t0 + 16 * (n + 1 + int'(pen)) + 8);
    chk(txd == 1'b1, "R2 stop bit", txd, 1);
  endtask

  initial begin
    int t0, tp, nf;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 reset txd", txd, 1);
    chk(tx_empty == 1'b1, "R1 reset tx_empty", tx_empty, 1);
    chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
    tick_en = 1'b1;

    // Table walk: every length and parity mode
    for (int v = 0; v < 8; v++) begin
      cfg_len = VEC[v][11:10];
      cfg_par_en = VEC[v][9];
      cfg_par_odd = VEC[v][8];
      push(VEC[v][7:0]);
      chk(tx_empty == 1'b0, "R9 busy after push", tx_empty, 0);
      rx_frame(VEC[v][11:10], VEC[v][9], VEC[v][8], VEC[v][7:0], t0);
      nf = 7 + int'(VEC[v][11:10]) + int'(VEC[v][9]);
      wait_tick(t0 + 16 * nf - 1);
      chk(tx_empty == 1'b0, "R9 still busy before end", tx_empty, 0);
      wait_tick(t0 + 16 * nf);
      chk(tx_empty == 1'b1, "R9 empty at stop end", tx_empty, 1);
      chk(txd == 1'b1, "R1 idle high", txd, 1);
    end

    // R5: settings changed mid-frame do not alter the frame
    cfg_len = 2'd3; cfg_par_en = 1'b0;
    push(8'hA5);
    find_start(t0);
    wait_tick(t0 + 20);
    cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
    wait_tick(t0 + 16 * 8 + 8);
    chk(txd == 1'b1, "R5 bit7 kept", txd, 1);
    wait_tick(t0 + 16 * 9 + 8);
    chk(txd == 1'b1, "R5 stop after 8 bits", txd, 1);
    wait_tick(t0 + 160);
    chk(tx_empty == 1'b1, "R5 frame length kept", tx_empty, 1);
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

    // R6: break mid-frame holds low, timing kept
    push(8'h55);
    find_start(t0);
    wait_tick(t0 + 20);
    cfg_brk = 1'b1;
    #0.1;
    chk(txd == 1'b0, "R6 break immediate", txd, 0);
    wait_tick(t0 + 40);
    chk(txd == 1'b0, "R6 break over one bit", txd, 0);
    wait_tick(t0 + 50);
    cfg_brk = 1'b0;
    wait_tick(t0 + 16 * 5 + 8);
    chk(txd == 1'b1, "R6 data bit4 after break", txd, 1);
    wait_tick(t0 + 159);
    chk(tx_empty == 1'b0, "R6 busy before end", tx_empty, 0);
    wait_tick(t0 + 160);
    chk(tx_empty == 1'b1, "R6 end time kept", tx_empty, 1);

    // R10: no ticks means no movement
    push(8'h33);
    find_start(t0);
    wait_tick(t0 + 40);
    tick_en = 1'b0;
    repeat (60) @(negedge clk);
    chk(txd == 1'b1, "R10 line held without ticks", txd, 1);
    chk(tx_empty == 1'b0, "R10 still busy", tx_empty, 0);
    tp = tick_count;
    tick_en = 1'b1;
    wait_tick(t0 + 16 * 3 + 8);
    chk(txd == 1'b0, "R10 resumes at data bit2", txd, 0);
    wait_tick(t0 + 160);
    chk(tx_empty == 1'b1, "R10 ends on schedule", tx_empty, 1);

    // R8 / R7: fill the queue, reject one, drain back-to-back
    tick_en = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i++) push(8'(i * 17 + 3));
    chk(in_ready == 1'b0, "R8 ready low when full", in_ready, 0);
    in_valid = 1'b1; in_data = 8'hEE;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R8 still full after reject", in_ready, 0);
    tick_en = 1'b1;
    tp = 0;
    for (int i = 0; i < 16; i++) begin
      rx_frame(2'd3, 1'b0, 1'b0, 8'(i * 17 + 3), t0);
      if (i == 1) chk(in_ready == 1'b1, "R8 ready after drain", in_ready, 1);
      if (i > 0) chk(t0 == tp + 160, "R7 back-to-back start", t0, tp + 160);
      tp = t0;
    end
    wait_tick(tp + 160);
    chk(tx_empty == 1'b1, "R9 empty after last", tx_empty, 1);
    wait_tick(tp + 300);
    chk(txd == 1'b1 && tx_empty == 1'b1, "R8 rejected byte never sent", txd, 1);

    finish_run();
  end
endmodule